// File: doc/BRIEF.md
# Bitfield Extract Unit with Condition Flags

This block pulls a contiguous run of bits out of a 32-bit source word and returns it right-aligned in a 32-bit result. The result is padded above the field with zeros, or with copies of the field's top bit when signed mode is selected. One 32-bit control operand carries both the field length and the start position. Bits of the control operand above the length byte are don't-care.

When the flag-update input is high, the operation also refreshes four condition flags. Zero and sign are computed from the result, and carry and overflow are cleared. When flag-update is low, the flags keep their values.

Each operation is accepted with a valid/ready handshake. The result is presented from a single output register that also uses a valid/ready handshake. A field that would run past bit 31 is cut off at bit 31. A start position of 32 or more selects no bits at all.

Top module: `bfx_unit`

## Requirements
- R1: The start position is control bits [7:0] and the field length is control bits [15:8]. Control bits [31:16] have no effect on the result or the flags.
- R2: A field length of zero gives a result of 0x00000000 in both signed and unsigned mode.
- R3: In unsigned mode (in_signed = 0), bits [pos+len-1:pos] of the source appear at result bits [len-1:0], and all higher result bits are zero.
- R4: In signed mode (in_signed = 1), the field appears at the bottom of the result, and every result bit above it equals the field's most significant bit.
- R5: Field bits at positions above 31 are absent. The usable length is min(len, 32-pos). In signed mode the sign comes from source bit 31 when the field is cut off. A start position of 32 or more gives zero.
- R6: An accepted operation with in_upd_flags = 1 sets flag_z to 1 exactly when its result is zero.
- R7: An accepted operation with in_upd_flags = 1 sets flag_n to bit 31 of its result.
- R8: An accepted operation with in_upd_flags = 1 clears flag_c and flag_v.
- R9: The flags change only on the cycle after an operation with in_upd_flags = 1 is accepted. Otherwise all four keep their values.
- R10: An operation accepted at a clock edge (in_valid and in_ready both high) appears on out_result with out_valid high after that edge. in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, out_result and out_valid hold.
- R11: After synchronous reset, out_valid is 0, out_result is zero, all four flags are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_src | input | 32 | Source word |
| in_ctl | input | 32 | Control operand: [7:0] start, [15:8] length |
| in_signed | input | 1 | 1 = sign-extend the field, 0 = zero-extend |
| in_upd_flags | input | 1 | 1 = refresh the condition flags with this operation |
| out_valid | output | 1 | out_result holds an undelivered result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Extracted field, extended to 32 bits |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Sign (negative) flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Both the result and the flags pass through one register level. Everything an operation produces is therefore due after the first rising edge at which in_valid and in_ready are both high. The bench drives inputs on the falling edge and checks result, out_valid and all four flags on the next falling edge, half a period after the accepting edge. The stall case holds out_ready low across one extra edge. It checks that nothing moved and that in_ready stayed low. It then checks that the next operation lands one edge after the stall is released.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        sel_t len;
        sel_t pos;
    } fsel_t;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        word_t  src;
        fsel_t  sel;
        logic   sgn;
        logic   upd;
    } op_t;

    function automatic fsel_t split_ctl(word_t ctl);
        fsel_t s;
        s.pos = ctl[SEL_W-1:0];
        s.len = ctl[2*SEL_W-1:SEL_W];
        return s;
    endfunction

endpackage

// File: rtl/bfx_span.sv
module bfx_span
    import bfx_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int SW    = SEL_W,
    parameter int CW    = CNT_W
) (
    input  logic [SW-1:0] pos,
    input  logic [SW-1:0] len,
    output logic [CW-1:0] eff
);
    localparam logic [SW:0] LIM = W[SW:0];

    logic [SW:0] pos_x, len_x, room, cnt_x;

    always_comb begin
        pos_x = {1'b0, pos};
        len_x = {1'b0, len};
        room  = '0;
        cnt_x = '0;
        if (pos_x < LIM) begin
            room  = LIM - pos_x;
            cnt_x = (len_x > room) ? room : len_x;
        end
        eff = cnt_x[CW-1:0];
    end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract
    import bfx_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = SEL_W,
    parameter int CW = CNT_W
) (
    input  logic [W-1:0]  src,
    input  logic [SW-1:0] pos,
    input  logic [CW-1:0] eff,
    input  logic          sgn,
    output logic [W-1:0]  res
);
    logic [W-1:0] shifted, mask, top_bit;
    logic         msb;

    assign shifted = src >> pos;

    for (genvar i = 0; i < W; i++) begin : g_mask
        localparam logic [CW-1:0] IDX = CW'(i);
        assign mask[i] = (IDX < eff);
    end

    assign top_bit = mask & ~(mask >> 1);
    assign msb     = |(shifted & top_bit);
    assign res     = (shifted & mask) | ((sgn && msb) ? ~mask : '0);
endmodule

// File: rtl/bfx_flags.sv
module bfx_flags
    import bfx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    input  logic         upd,
    input  flags_t       prev,
    output flags_t       next
);
    always_comb begin
        next = prev;
        if (upd) begin
            next.z = (res == '0);
            next.n = res[W-1];
            next.c = 1'b0;
            next.v = 1'b0;
        end
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_src,
    input  logic [31:0] in_ctl,
    input  logic        in_signed,
    input  logic        in_upd_flags,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_result,
    output logic        flag_z,
    output logic        flag_n,
    output logic        flag_c,
    output logic        flag_v
);
    op_t    op;
    cnt_t   eff;
    word_t  res_d, res_q;
    flags_t fl_q, fl_d;
    logic   vld_q, acc;

    always_comb begin
        op.src = in_src;
        op.sel = split_ctl(in_ctl);
        op.sgn = in_signed;
        op.upd = in_upd_flags;
    end

    assign in_ready = !vld_q || out_ready;
    assign acc      = in_valid && in_ready;

    bfx_span u_span (
        .pos (op.sel.pos),
        .len (op.sel.len),
        .eff (eff)
    );

    bfx_extract u_ext (
        .src (op.src),
        .pos (op.sel.pos),
        .eff (eff),
        .sgn (op.sgn),
        .res (res_d)
    );

    bfx_flags u_flg (
        .res  (res_d),
        .upd  (op.upd),
        .prev (fl_q),
        .next (fl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            fl_q  <= '0;
        end else begin
            vld_q <= acc || (vld_q && !out_ready);
            if (acc) begin
                res_q <= res_d;
                fl_q  <= fl_d;
            end
        end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;
    assign flag_z     = fl_q.z;
    assign flag_n     = fl_q.n;
    assign flag_c     = fl_q.c;
    assign flag_v     = fl_q.v;

    p_len_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && in_ctl[15:8] == 8'd0) |=> (out_result == 32'd0));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && in_upd_flags) |=> (flag_z == (out_result == 32'd0)));

    p_sign_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && in_upd_flags) |=> (flag_n == out_result[31]));

    p_cv_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && in_upd_flags) |=> (!flag_c && !flag_v));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(acc && in_upd_flags) |=> ($stable(flag_z) && $stable(flag_n) &&
                                    $stable(flag_c) && $stable(flag_v)));

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
endmodule

// File: tb/bfx_unit_test.sv
module bfx_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_signed = 1'b0, in_upd_flags = 1'b0, out_ready = 1'b1;
    logic [31:0] in_src = '0, in_ctl = '0;
    logic        in_ready, out_valid, flag_z, flag_n, flag_c, flag_v;
    logic [31:0] out_result;

    int   n_chk = 0, n_fail = 0;
    logic mz = 0, mn = 0, mc = 0, mv = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfx_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_ctl(in_ctl), .in_signed(in_signed),
        .in_upd_flags(in_upd_flags), .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(logic [31:0] src, int pos, int len, bit sgn);
        longint unsigned v;
        int eff;
        if (pos >= 32 || len == 0) return 32'd0;
        eff = (len > 32 - pos) ? 32 - pos : len;
        v = ({32'd0, src} >> pos) % (64'd1 << eff);
        if (sgn && v >= (64'd1 << (eff - 1))) v = v - (64'd1 << eff);
        return v[31:0];
    endfunction

    task automatic model_flags(logic [31:0] r, bit upd);
        if (upd) begin
            mz = (r == 0); mn = r[31]; mc = 0; mv = 0;
        end
    endtask

    task automatic drive(logic [31:0] src, int pos, int len, bit sgn, bit upd, logic [15:0] hi);
        in_valid = 1'b1; in_src = src; in_signed = sgn; in_upd_flags = upd;
        in_ctl = {hi, 8'(len), 8'(pos)};
    endtask

    task automatic check_flags(bit upd);
        if (upd) begin
            check("R6 flag_z", {31'd0, flag_z}, {31'd0, mz});
            check("R7 flag_n", {31'd0, flag_n}, {31'd0, mn});
            check("R8 flag_c/flag_v", {30'd0, flag_c, flag_v}, 32'd0);
        end else begin
            check("R9 flags held", {28'd0, flag_z, flag_n, flag_c, flag_v},
                  {28'd0, mz, mn, mc, mv});
        end
    endtask

    task automatic run_op(logic [31:0] src, int pos, int len, bit sgn, bit upd, logic [15:0] hi);
        logic [31:0] exp;
        string req;
        @(negedge clk);
        drive(src, pos, len, sgn, upd, hi);
        exp = model(src, pos, len, sgn);
        model_flags(exp, upd);
        if (len == 0) req = "R2";
        else if (pos >= 32 || pos + len > 32) req = "R5";
        else if (sgn) req = "R4";
        else req = "R3";
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 out_valid after accept", {31'd0, out_valid}, 32'd1);
        check(req, out_result, exp);
        check_flags(upd);
    endtask

    initial begin
        logic [31:0] srcs [3];
        logic [31:0] ra, rb, e;
        srcs[0] = 32'h8F3C_A561; srcs[1] = 32'hFFFF_FFFF; srcs[2] = 32'h0000_0000;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R11 reset state
        check("R11 out_valid", {31'd0, out_valid}, 32'd0);
        check("R11 out_result", out_result, 32'd0);
        check("R11 flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, 32'd0);
        check("R11 in_ready", {31'd0, in_ready}, 32'd1);

        // R1: upper control bits ignored
        run_op(32'hDEAD_BEEF, 4, 12, 1, 1, 16'h0000);
        ra = out_result;
        run_op(32'hDEAD_BEEF, 4, 12, 1, 1, 16'hFFFF);
        rb = out_result;
        check("R1 upper ctl bits ignored", rb, ra);

        // Near-exhaustive sweep of position, length, mode
        for (int s = 0; s < 3; s++)
            for (int p = 0; p < 36; p++)
                for (int l = 0; l < 36; l++)
                    for (int g = 0; g < 2; g++)
                        run_op(srcs[s], p, l, g[0], ((p + l + g) % 3) != 0,
                               16'(p * 37 + l * 11) ^ 16'hB6D1); // R1 garbage high bits

        // R10 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        drive(32'h1234_5678, 8, 8, 0, 1, 16'h0);
        e = model(32'h1234_5678, 8, 8, 0);
        model_flags(e, 1);
        @(negedge clk);
        check("R10 first result", out_result, e);
        drive(32'hF000_0000, 28, 8, 1, 1, 16'h0);
        check("R10 in_ready low under stall", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        check("R10 out_valid held", {31'd0, out_valid}, 32'd1);
        check("R10 result held", out_result, e);
        check_flags(1);
        out_ready = 1'b1;
        e = model(32'hF000_0000, 28, 8, 1);
        check("R5 expect sign from bit31", e, 32'hFFFF_FFFF);
        model_flags(e, 1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second result after release", out_result, e);
        check_flags(1);
        @(negedge clk);
        check("R10 out_valid drops", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule